// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date in packed BCD. A base tick enable is divided by a parameterised prescaler into hundredths of a second. The hundredths then ripple through seconds, minutes, 24-hour hours, day of week, date, month and year. A two-digit year is extended by a century bit that can be told to flip when the year wraps.

Two copies of the time exist. The running copy is the one that counts and the one that writes land in. The visible copy is what the read port returns. The visible copy takes a snapshot of every running field at once on each clock, except while the freeze input is high. A bus front end raises freeze while it reads a clock register, so that a multi-byte read sees a consistent time. Counting goes on underneath, so no time is lost.

Any write restarts the sub-second phase: the hundredths field becomes 00 and the prescaler starts over. A stop bit halts counting altogether.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers at addresses 0 to 7 read 00, 00, 00, 00, 01, 01, 01, 00. The stop bit is 0 and both century bits are 0.
- R2: Address 0 holds the hundredths of a second (00–99). It advances by one on every TICK_DIV-th cycle with tick_en high. Each field carries into the next only when it wraps: hundredths 99, seconds 59, minutes 59, hours 23.
- R3: Address 4 bits 2:0 hold the day of week. It steps by one at each midnight, and 7 wraps to 1.
- R4: Address 5 holds the date and address 6 the month. The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. February ends on 29 when the binary value of the year (address 7) is a multiple of 4, year 00 included, and on 28 otherwise.
- R5: Address 3 holds the hours in bits 5:0, the century enable in bit 7 and the century bit in bit 6. When the year wraps from 99 to 00, the century bit inverts if the enable is 1. It never changes by counting while the enable is 0.
- R6: A write to any address sets the hundredths to 00 and restarts the prescaler. The next hundredths step then comes after a full TICK_DIV tick cycles. The data written to address 0 is ignored.
- R7: Address 1 bit 7 is the stop bit and bits 6:0 hold the seconds. While the stop bit is 1 no field advances. After it is written to 0, counting resumes.
- R8: While freeze is low, the visible copy takes all running values one cycle after they change. While freeze is high, the visible copy holds, even across writes and count steps. Once freeze drops, the visible copy shows the current running values.
- R9: Unused bits read back as 0 and ignore writes: minutes bit 7, day bits 7:3, date bits 7:6 and month bits 7:5.
- R10: rd_data returns the visible copy of the register selected by rd_addr, with no added clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Base tick enable; TICK_DIV of these make one hundredth |
| freeze | input | 1 | Holds the visible copy while high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register written |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register read |
| rd_data | output | 8 | Visible copy of the selected register |

## Verification
A table of start times is loaded by writes. For each one the bench runs exactly one second of ticks and then compares every field.

The start times are chosen so that one carry path is exercised per entry:
- a plain second step and a minute wrap;
- a midnight with a day-of-week wrap;
- the ends of 30-day, 31-day and February months in both leap and ordinary years, year 00 among them;
- the three century-bit cases at year wrap.

These entries separate an off-by-one in a rollover limit from a wrong month-length choice and from a stray century flip.

Directed runs cover three further areas:
- prescaler phase: a partial count followed by a write, so that a divider that is not restarted shows up as an early step;
- the stop bit;
- freeze held across both counting and a write.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       freeze,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(TICK_DIV - 1);
  localparam logic [63:0] RST_IMAGE = 64'h00_01_01_01_00_00_00_00;

  logic [7:0] cs, yr;
  logic [6:0] sec, min;
  logic [5:0] hr, date;
  logic [4:0] mon;
  logic [2:0] dow;
  logic       stop, cen_en, cen;
  logic [DIV_W-1:0] div;
  logic [7:0][7:0] run_w, usr_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'h0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign run_w = {yr, 3'b0, mon, 2'b0, date, 5'b0, dow, cen_en, cen, hr, 1'b0, min, stop, sec, cs};
  assign rd_data = usr_q[rd_addr];

  logic [6:0] yr_bin;
  logic       leap;
  logic [5:0] last_day;
  assign yr_bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
  assign leap   = (yr_bin[1:0] == 2'b00);

  always_comb begin
    case (mon)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end

  logic step, c_cs, c_sec, c_min, c_hr, c_date, c_mon, c_yr;
  assign step   = tick_en && !stop && (div == DIV_MAX);
  assign c_cs   = step   && (cs   == 8'h99);
  assign c_sec  = c_cs   && (sec  == 7'h59);
  assign c_min  = c_sec  && (min  == 7'h59);
  assign c_hr   = c_min  && (hr   == 6'h23);
  assign c_date = c_hr   && (date == last_day);
  assign c_mon  = c_date && (mon  == 5'h12);
  assign c_yr   = c_mon  && (yr   == 8'h99);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs <= 8'h00; sec <= 7'h00; stop <= 1'b0; min <= 7'h00;
      hr <= 6'h00; cen_en <= 1'b0; cen <= 1'b0; dow <= 3'd1;
      date <= 6'h01; mon <= 5'h01; yr <= 8'h00;
      div <= '0;
    end else if (wr_en) begin
      cs  <= 8'h00;
      div <= '0;
      case (wr_addr)
        3'd1: {stop, sec} <= wr_data;
        3'd2: min <= wr_data[6:0];
        3'd3: {cen_en, cen, hr} <= wr_data;
        3'd4: dow <= wr_data[2:0];
        3'd5: date <= wr_data[5:0];
        3'd6: mon <= wr_data[4:0];
        3'd7: yr <= wr_data;
        default: ;
      endcase
    end else if (tick_en && !stop) begin
      div <= (div == DIV_MAX) ? '0 : div + 1'b1;
      if (step)   cs   <= c_cs ? 8'h00 : bcd_inc(cs);
      if (c_cs)   sec  <= c_sec ? 7'h00 : 7'(bcd_inc({1'b0, sec}));
      if (c_sec)  min  <= c_min ? 7'h00 : 7'(bcd_inc({1'b0, min}));
      if (c_min)  hr   <= c_hr ? 6'h00 : 6'(bcd_inc({2'b0, hr}));
      if (c_hr)   dow  <= (dow == 3'd7) ? 3'd1 : dow + 3'd1;
      if (c_hr)   date <= c_date ? 6'h01 : 6'(bcd_inc({2'b0, date}));
      if (c_date) mon  <= c_mon ? 5'h01 : 5'(bcd_inc({3'b0, mon}));
      if (c_mon)  yr   <= c_yr ? 8'h00 : bcd_inc(yr);
      if (c_yr && cen_en) cen <= ~cen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       usr_q <= RST_IMAGE;
    else if (!freeze) usr_q <= run_w;
  end

  p_wr_zero_subsec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (run_w[0] == 8'h00));
  p_stop_holds_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_en) |=> $stable(run_w));
  p_view_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(usr_q));
  p_view_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> (usr_q == $past(run_w)));
  p_century_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cen_en) |=> $stable(cen));
  p_dow_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && c_hr && dow == 3'd7) |=> (dow == 3'd1));
endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, freeze = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  localparam int DIV = 4;

  bcd_calendar #(.TICK_DIV(DIV)) u_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  always #10 clk = ~clk;

  // start bytes: sec min hr dow date mon yr | expected after one second
  localparam logic [111:0] VEC [13] = '{
    {56'h00_00_00_01_05_03_24, 56'h01_00_00_01_05_03_24},
    {56'h59_12_10_02_05_03_24, 56'h00_13_10_02_05_03_24},
    {56'h59_59_23_07_15_06_30, 56'h00_00_00_01_16_06_30},
    {56'h59_59_23_03_28_02_23, 56'h00_00_00_04_01_03_23},
    {56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24},
    {56'h59_59_23_05_29_02_24, 56'h00_00_00_06_01_03_24},
    {56'h59_59_23_01_30_04_25, 56'h00_00_00_02_01_05_25},
    {56'h59_59_23_01_30_01_25, 56'h00_00_00_02_31_01_25},
    {56'h59_59_E3_06_31_12_99, 56'h00_00_80_07_01_01_00},
    {56'h59_59_23_06_31_12_99, 56'h00_00_00_07_01_01_00},
    {56'h59_59_63_06_31_12_99, 56'h00_00_40_07_01_01_00},
    {56'h59_59_23_02_28_02_00, 56'h00_00_00_03_29_02_00},
    {56'h59_59_A3_04_30_09_41, 56'h00_00_80_05_01_10_41}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rdchk(input string req, input logic [2:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset image
    rdchk("R1 hundredths", 3'd0, 8'h00);
    rdchk("R1 seconds", 3'd1, 8'h00);
    rdchk("R1 minutes", 3'd2, 8'h00);
    rdchk("R1 hours", 3'd3, 8'h00);
    rdchk("R1 day", 3'd4, 8'h01);
    rdchk("R1 date", 3'd5, 8'h01);
    rdchk("R1 month", 3'd6, 8'h01);
    rdchk("R1 year", 3'd7, 8'h00);

    // one second from each start time: R2 R3 R4 R5 R10
    for (int v = 0; v < 13; v++) begin
      for (int k = 0; k < 7; k++) wr(3'(k + 1), VEC[v][111 - 8*k -: 8]);
      ticks(100 * DIV);
      settle();
      rdchk("R2 vector hundredths", 3'd0, 8'h00);
      for (int k = 0; k < 7; k++)
        rdchk($sformatf("R2 R3 R4 R5 R10 vector %0d reg %0d", v, k + 1), 3'(k + 1), VEC[v][55 - 8*k -: 8]);
    end

    // R2 rate and BCD digit carry, R6 restart
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    ticks(37 * DIV + 2);
    settle();
    rdchk("R2 hundredths rate", 3'd0, 8'h37);
    wr(3'd0, 8'h55);
    settle();
    rdchk("R6 hundredths cleared, data ignored", 3'd0, 8'h00);
    ticks(DIV - 1);
    settle();
    rdchk("R6 prescaler restarted", 3'd0, 8'h00);
    ticks(1);
    settle();
    rdchk("R6 first step after full period", 3'd0, 8'h01);
    ticks(9 * DIV);
    settle();
    rdchk("R2 digit carry 09 to 10", 3'd0, 8'h10);
    wr(3'd2, 8'h07);
    settle();
    rdchk("R6 minute write clears hundredths", 3'd0, 8'h00);
    rdchk("R6 minute written", 3'd2, 8'h07);

    // R7 stop bit
    wr(3'd1, 8'h90);
    ticks(200 * DIV);
    settle();
    rdchk("R7 stopped seconds", 3'd1, 8'h90);
    rdchk("R7 stopped hundredths", 3'd0, 8'h00);
    wr(3'd1, 8'h10);
    ticks(100 * DIV);
    settle();
    rdchk("R7 resumed", 3'd1, 8'h11);

    // R8 freeze
    wr(3'd1, 8'h20);
    @(negedge clk);
    freeze = 1'b1;
    ticks(100 * DIV);
    settle();
    rdchk("R8 frozen across counting", 3'd1, 8'h20);
    wr(3'd2, 8'h45);
    settle();
    rdchk("R8 frozen across write", 3'd2, 8'h07);
    freeze = 1'b0;
    settle();
    settle();
    rdchk("R8 released seconds kept counting", 3'd1, 8'h21);
    rdchk("R8 released write visible", 3'd2, 8'h45);

    // R9 unused bits
    wr(3'd4, 8'hFF); settle(); rdchk("R9 day mask", 3'd4, 8'h07);
    wr(3'd6, 8'hF2); settle(); rdchk("R9 month mask", 3'd6, 8'h12);
    wr(3'd2, 8'hD9); settle(); rdchk("R9 minute mask", 3'd2, 8'h59);
    wr(3'd5, 8'hE5); settle(); rdchk("R9 date mask", 3'd5, 8'h25);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule